// File: doc/BRIEF.md
# Word DMA Channel with Fill Mode

A single memory-to-memory DMA channel that moves 32-bit words over a simple word-wide bus master. Software programs a small register window with a source address, a destination address, a byte count, a fill constant and a control word. Setting the start bit launches the transfer. The channel then either copies words from source to destination or, in fill mode, writes the fill constant to every destination word without reading anything.

Each address can be set to advance by 4 per word or to stay fixed. Writing an address register also loads a private working copy, and only the working copy moves during a transfer. A second transfer started without rewriting the addresses therefore continues where the first one stopped. When the last word has been written, the start bit clears and, if enabled, an interrupt flag is raised.

Top module: `word_dma_channel`

## Requirements
- R1: After reset the control word reads 0 (not busy), the address, count and fill registers read 0, `irq` is low and neither bus request is asserted.
- R2: The register offsets (`reg_addr`) are: source 0x04, destination 0x08, byte count 0x0c, fill 0x18, control 0x1c. Each register reads back what was written. The control word keeps only bit 31 (start/busy), bit 30 (interrupt enable), bit 14 (source fixed), bit 13 (fill mode) and bit 11 (destination fixed); its other bits read 0. Any other offset reads 0.
- R3: In copy mode, each word is first read from the working source address and the returned data is then written to the working destination address. The number of words is the byte count shifted right by two; the two low count bits are ignored.
- R4: After each accepted write, the working source address advances by 4 unless control bit 14 is set, and the working destination address advances by 4 unless bit 11 is set. The programmed address registers read back unchanged. A later transfer that is started without rewriting the addresses continues from the advanced working addresses.
- R5: With control bit 13 set, no read request is issued, and every write carries the fill register value.
- R6: Control bit 31 reads 1 throughout a transfer. It reads 0 from the cycle after the last write is accepted.
- R7: If bit 30 is set, `irq` rises in the same cycle that bit 31 clears at the end of a transfer, and it stays high until a control write with bit 30 equal to 0 (made while idle). If bit 30 is clear, `irq` stays low.
- R8: While bit 31 is set, writes to any register, including the control word, are ignored.
- R9: A start with a word count of zero issues no bus request. Bit 31 reads 1 for one cycle and then clears, and `irq` is raised as in R7.
- R10: A bus request that is not accepted (`m_ready` low) is held with the same address and write data on the next cycle. A read request and a write request are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset within the register window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| m_rd_req | output | 1 | Bus read request |
| m_wr_req | output | 1 | Bus write request |
| m_addr | output | AW | Bus address of the current request |
| m_wdata | output | 32 | Bus write data |
| m_ready | input | 1 | The bus accepts the current request at this edge |
| m_rvalid | input | 1 | Read data is valid |
| m_rdata | input | 32 | Read data |
| irq | output | 1 | Completion interrupt flag |

## Verification
A register write takes effect at the clock edge that samples `reg_wr`, and the readback is combinational, so each value is checked at the next falling edge. Busy clears one edge after the last write is accepted. The bench's bus model records the cycle of every accepted write and requires the first idle readback to fall in exactly the following cycle. For a zero-length start, the bench requires busy to read 1 at the first falling edge after the write and 0, with `irq` high, at the second. Read data returns one cycle after a read is accepted. Stalls on every third cycle force the hold and stability checks.

// File: rtl/word_dma_channel.sv
`timescale 1ns/1ps
module word_dma_channel #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          m_rd_req,
  output logic          m_wr_req,
  output logic [AW-1:0] m_addr,
  output logic [31:0]   m_wdata,
  input  logic          m_ready,
  input  logic          m_rvalid,
  input  logic [31:0]   m_rdata,
  output logic          irq
);
  localparam logic [4:0] OFS_SRC  = 5'h04;
  localparam logic [4:0] OFS_DST  = 5'h08;
  localparam logic [4:0] OFS_CNT  = 5'h0c;
  localparam logic [4:0] OFS_FILL = 5'h18;
  localparam logic [4:0] OFS_CTRL = 5'h1c;
  localparam int B_BUSY = 31, B_IE = 30, B_SFIX = 14, B_FILL = 13, B_DFIX = 11;
  localparam int WCW = CW - 2;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_RWAIT, S_WR} st_t;

  st_t            st;
  logic [AW-1:0]  src_reg, dst_reg, src_w, dst_w;
  logic [CW-1:0]  cnt_reg;
  logic [31:0]    fill_reg, data_q, ctrl_rd;
  logic [WCW-1:0] rem;
  logic           busy, c_ie, c_sfix, c_fill, c_dfix, irq_q;

  wire wr_ok   = reg_wr && !busy;
  wire no_work = (cnt_reg[CW-1:2] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src_reg <= '0; dst_reg <= '0; src_w <= '0; dst_w <= '0;
      cnt_reg <= '0; fill_reg <= '0; data_q <= '0; rem <= '0;
      busy <= 1'b0; c_ie <= 1'b0; c_sfix <= 1'b0; c_fill <= 1'b0; c_dfix <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (reg_addr)
          OFS_SRC:  begin src_reg <= reg_wdata[AW-1:0]; src_w <= reg_wdata[AW-1:0]; end
          OFS_DST:  begin dst_reg <= reg_wdata[AW-1:0]; dst_w <= reg_wdata[AW-1:0]; end
          OFS_CNT:  cnt_reg <= reg_wdata[CW-1:0];
          OFS_FILL: fill_reg <= reg_wdata;
          OFS_CTRL: begin
            busy   <= reg_wdata[B_BUSY];
            c_ie   <= reg_wdata[B_IE];
            c_sfix <= reg_wdata[B_SFIX];
            c_fill <= reg_wdata[B_FILL];
            c_dfix <= reg_wdata[B_DFIX];
            if (!reg_wdata[B_IE]) irq_q <= 1'b0;
          end
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (busy) begin
          if (no_work) begin
            busy <= 1'b0;
            if (c_ie) irq_q <= 1'b1;
          end else begin
            rem <= cnt_reg[CW-1:2];
            st  <= c_fill ? S_WR : S_RD;
          end
        end
        S_RD:    if (m_ready) st <= S_RWAIT;
        S_RWAIT: if (m_rvalid) begin data_q <= m_rdata; st <= S_WR; end
        S_WR: if (m_ready) begin
          if (!c_dfix) dst_w <= dst_w + AW'(4);
          if (!c_sfix && !c_fill) src_w <= src_w + AW'(4);
          rem <= rem - WCW'(1);
          if (rem == WCW'(1)) begin
            st   <= S_IDLE;
            busy <= 1'b0;
            if (c_ie) irq_q <= 1'b1;
          end else begin
            st <= c_fill ? S_WR : S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign m_rd_req = (st == S_RD);
  assign m_wr_req = (st == S_WR);
  assign m_addr   = (st == S_WR) ? dst_w : src_w;
  assign m_wdata  = c_fill ? fill_reg : data_q;
  assign irq      = irq_q;

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[B_BUSY] = busy;
    ctrl_rd[B_IE]   = c_ie;
    ctrl_rd[B_SFIX] = c_sfix;
    ctrl_rd[B_FILL] = c_fill;
    ctrl_rd[B_DFIX] = c_dfix;
    case (reg_addr)
      OFS_SRC:  reg_rdata = 32'(src_reg);
      OFS_DST:  reg_rdata = 32'(dst_reg);
      OFS_CNT:  reg_rdata = 32'(cnt_reg);
      OFS_FILL: reg_rdata = fill_reg;
      OFS_CTRL: reg_rdata = ctrl_rd;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/word_dma_channel_chk.sv
`timescale 1ns/1ps
module word_dma_channel_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_rd_req,
  input logic          m_wr_req,
  input logic          m_ready,
  input logic [AW-1:0] m_addr,
  input logic [31:0]   m_wdata,
  input logic          irq,
  input logic          busy,
  input logic          c_ie,
  input logic          c_fill,
  input logic          c_dfix,
  input logic [AW-1:0] dst_w
);
  p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_rd_req && m_wr_req));
  p_hold_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_wr_req && !m_ready |=> m_wr_req && $stable(m_addr) && $stable(m_wdata));
  p_hold_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_rd_req && !m_ready |=> m_rd_req && $stable(m_addr));
  p_fill_noread_r5: assert property (@(posedge clk) disable iff (!rst_n)
    c_fill |-> !m_rd_req);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_rd_req && !m_wr_req);
  p_irq_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> c_ie && $fell(busy));
  p_dst_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_wr_req && m_ready && c_dfix |=> $stable(dst_w));
endmodule

bind word_dma_channel word_dma_channel_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_word_dma_channel.sv
`timescale 1ns/1ps
module test_word_dma_channel;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        m_rd_req, m_wr_req, m_ready, m_rvalid, irq;
  logic [31:0] m_addr, m_wdata, m_rdata;

  word_dma_channel i_word_dma_channel (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, nwr = 0, nrd = 0, n_both = 0, n_unstable = 0, last_wr_cyc = 0;
  bit stall_en = 0;
  logic [31:0] mem [0:63];
  logic [31:0] wa [0:63], wd [0:63], ra [0:63];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    bit pend = 0, prv_hold = 0, prv_rd = 0, prv_wr = 0;
    logic [5:0] ridx = 0;
    logic [31:0] prv_addr = 0, prv_data = 0;
    for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 + i;
    m_ready = 0; m_rvalid = 0; m_rdata = 0;
    forever begin
      @(negedge clk);
      cyc++;
      m_rvalid = pend;
      m_rdata  = mem[ridx];
      pend = 0;
      if (m_rd_req && m_wr_req) n_both++;
      if (prv_hold && !(m_rd_req == prv_rd && m_wr_req == prv_wr && m_addr == prv_addr
                        && (!prv_wr || m_wdata == prv_data))) n_unstable++;
      m_ready = !stall_en || (cyc % 3 != 1);
      if (m_wr_req && m_ready) begin
        if (nwr < 64) begin wa[nwr] = m_addr; wd[nwr] = m_wdata; end
        mem[m_addr[7:2]] = m_wdata;
        nwr++;
        last_wr_cyc = cyc;
      end
      if (m_rd_req && m_ready) begin
        if (nrd < 64) ra[nrd] = m_addr;
        nrd++;
        pend = 1;
        ridx = m_addr[7:2];
      end
      prv_hold = (m_rd_req || m_wr_req) && !m_ready;
      prv_rd = m_rd_req; prv_wr = m_wr_req; prv_addr = m_addr; prv_data = m_wdata;
    end
  end

  task automatic reg_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_logs();
    nwr = 0; nrd = 0;
  endtask

  task automatic wait_done(string tag);
    int k;
    reg_addr = 5'h1c;
    for (k = 0; k < 600; k++) begin
      @(negedge clk);
      #1;
      if (!reg_rdata[31]) break;
    end
    chk({tag, " R6 finished"}, k < 600, 1);
    chk({tag, " R6 busy clears cycle after last write"}, cyc, last_wr_cyc + 1);
  endtask

  task automatic check_writes(string tag, int n, logic [31:0] a0, logic [31:0] as,
                              logic [31:0] d0, logic [31:0] ds);
    chk({tag, " write count"}, nwr, n);
    for (int i = 0; i < n && i < nwr; i++) begin
      chk({tag, " write addr"}, wa[i], a0 + as * i);
      chk({tag, " write data"}, wd[i], d0 + ds * i);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(5'h1c, v); chk("R1 ctrl after reset", v, 0);
    reg_read(5'h04, v); chk("R1 src after reset", v, 0);
    reg_read(5'h18, v); chk("R1 fill after reset", v, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 no request after reset", {m_rd_req, m_wr_req}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    reg_write(5'h04, 32'h0000_1234); reg_read(5'h04, v); chk("R2 src readback", v, 32'h1234);
    reg_write(5'h08, 32'h0000_5678); reg_read(5'h08, v); chk("R2 dst readback", v, 32'h5678);
    reg_write(5'h0c, 32'h0000_0abc); reg_read(5'h0c, v); chk("R2 cnt readback", v, 32'h0abc);
    reg_write(5'h18, 32'hcafe_f00d); reg_read(5'h18, v); chk("R2 fill readback", v, 32'hcafe_f00d);
    reg_write(5'h1c, 32'h7fff_ffff); reg_read(5'h1c, v); chk("R2 ctrl kept bits", v, 32'h4000_6800);
    reg_read(5'h10, v); chk("R2 unmapped offset", v, 0);
    chk("R7 no irq without transfer", irq, 0);
    reg_write(5'h1c, 32'h0);
  endtask

  task automatic t_copy();
    logic [31:0] v;
    stall_en = 1; clear_logs();
    reg_write(5'h04, 32'h10); reg_write(5'h08, 32'h80); reg_write(5'h0c, 32'h13);
    reg_write(5'h1c, 32'hC000_0000);
    reg_read(5'h1c, v); chk("R6 busy during transfer", v[31], 1);
    wait_done("R3 copy");
    check_writes("R3 copy", 4, 32'h80, 4, 32'hA000_0004, 1);
    chk("R3 read count", nrd, 4);
    chk("R3 first read addr", ra[0], 32'h10);
    chk("R7 irq after copy", irq, 1);
    reg_read(5'h04, v); chk("R4 src register unchanged", v, 32'h10);
    reg_read(5'h08, v); chk("R4 dst register unchanged", v, 32'h80);
    stall_en = 0;
  endtask

  task automatic t_continue();
    clear_logs();
    reg_write(5'h0c, 32'h8);
    reg_write(5'h1c, 32'h8000_0000);
    wait_done("R4 continue");
    chk("R7 irq cleared by control write", irq, 0);
    check_writes("R4 continue", 2, 32'h90, 4, 32'hA000_0008, 1);
    chk("R4 continue read addr", ra[0], 32'h20);
  endtask

  task automatic t_fixed();
    clear_logs();
    reg_write(5'h04, 32'h04); reg_write(5'h08, 32'hC0); reg_write(5'h0c, 32'hC);
    reg_write(5'h1c, 32'h8000_4000);
    wait_done("R4 src fixed");
    check_writes("R4 src fixed", 3, 32'hC0, 4, 32'hA000_0001, 0);
    chk("R4 src fixed reads", nrd, 3);
    chk("R4 src fixed last read addr", ra[2], 32'h04);
    clear_logs();
    reg_write(5'h04, 32'h20); reg_write(5'h08, 32'hF0); reg_write(5'h0c, 32'h8);
    reg_write(5'h1c, 32'h8000_0800);
    wait_done("R4 dst fixed");
    check_writes("R4 dst fixed", 2, 32'hF0, 0, 32'hA000_0008, 1);
  endtask

  task automatic t_fill();
    clear_logs(); stall_en = 1;
    reg_write(5'h18, 32'hDEAD_BEEF); reg_write(5'h08, 32'h40); reg_write(5'h0c, 32'h10);
    reg_write(5'h1c, 32'h8000_2000);
    wait_done("R5 fill");
    check_writes("R5 fill", 4, 32'h40, 4, 32'hDEAD_BEEF, 0);
    chk("R5 fill issues no reads", nrd, 0);
    chk("R7 no irq when disabled", irq, 0);
    stall_en = 0;
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    clear_logs(); stall_en = 1;
    reg_write(5'h04, 32'h00); reg_write(5'h08, 32'h60); reg_write(5'h0c, 32'h18);
    reg_write(5'h1c, 32'hC000_0000);
    reg_write(5'h04, 32'h100); reg_write(5'h08, 32'h200); reg_write(5'h0c, 32'h4);
    reg_write(5'h18, 32'h1); reg_write(5'h1c, 32'h0);
    wait_done("R8 busy writes");
    check_writes("R8 busy writes", 6, 32'h60, 4, 32'hA000_0000, 1);
    reg_read(5'h04, v); chk("R8 src ignored", v, 32'h0);
    reg_read(5'h08, v); chk("R8 dst ignored", v, 32'h60);
    reg_read(5'h0c, v); chk("R8 cnt ignored", v, 32'h18);
    reg_read(5'h18, v); chk("R8 fill ignored", v, 32'hDEAD_BEEF);
    chk("R8 control write ignored, irq set", irq, 1);
    reg_write(5'h1c, 32'h0);
    chk("R7 irq cleared", irq, 0);
    stall_en = 0;
  endtask

  task automatic t_zero();
    logic [31:0] v;
    clear_logs();
    reg_write(5'h0c, 32'h3);
    reg_write(5'h1c, 32'hC000_0000);
    reg_read(5'h1c, v); chk("R9 busy for one cycle", v[31], 1);
    @(negedge clk);
    #1 chk("R9 busy cleared", reg_rdata[31], 0);
    chk("R9 irq raised", irq, 1);
    chk("R9 no bus activity", nwr + nrd, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_copy();
    t_continue();
    t_fixed();
    t_fill();
    t_busy_ignore();
    t_zero();
    chk("R10 never read and write together", n_both, 0);
    chk("R10 stalled request held", n_unstable, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule